// File: doc/BRIEF.md
# Program memory region decoder with off-chip wait-state control

This block sits between the instruction fetch unit of an 8-bit CPU and three program memory regions: an on-chip ROM, an on-chip RAM and an off-chip memory. Each cycle it takes a 24-bit address with a code-read or a code-write strobe and decides which region the address belongs to. It then drives that region's strobe and returns that region's read data to the CPU.

The ROM window starts at address zero and grows upward. The RAM window ends at 0xFFFF and grows downward. Each window's size comes from its own 3-bit size input. Any other address up to 0xFFFFFF goes to the off-chip memory. On-chip accesses finish in the cycle they are issued. An off-chip access stalls the CPU for a programmed number of wait cycles, and then for as long as the memory holds its ready line low.

The CPU must hold its request stable while the stall output is high. The access completes at the clock edge where stall is low.

Top module: `pmem_wait_ctrl`

## Requirements
- R1: The ROM window spans 0 to ROMsize-1. Size code 0 means an empty window. Size code n from 1 to 7 means 2^(n+9) bytes, so codes 1 to 7 give 1, 2, 4, 8, 16, 32 and 64 kB. A read inside the window raises `rom_rd`.
- R2: The RAM window spans 0x10000-RAMsize to 0xFFFF. RAMsize uses the same size coding as R1. Reads inside the window raise `ram_rd` and writes raise `ram_wr`.
- R3: Every other address goes off-chip on `ext_addr`, and reads raise `ext_rd`. Where the two windows overlap, the ROM window takes the address. At most one region strobe is high in any cycle.
- R4: An access to either on-chip window never raises `stall`.
- R5: An off-chip access with `ready` held high keeps `stall` high for exactly W cycles, where W is the programmed wait count. The access completes in cycle W+1.
- R6: After the wait count has run out, `stall` stays high for every cycle in which `ready` is low. An access whose ready line is low for its first M cycles stalls for max(W, M) cycles.
- R7: The wait count is a 3-bit register. It resets to 7 and is loaded from `ws_val` on a cycle where `ws_load` is high.
- R8: A write to the RAM window drives `wdata` onto `int_wdata` with `ram_wr`. A write off-chip drives `wdata` onto `ext_wdata` with `ext_wr`. A write inside the ROM window raises no strobe and no stall.
- R9: `rdata` carries the read data of the region the address decodes to. `int_addr` carries the low 16 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 24 | Fetch or write address |
| rd | input | 1 | Code read request |
| wr | input | 1 | Code write request |
| wdata | input | 8 | Write data from the CPU |
| rom_size | input | 3 | ROM window size code |
| ram_size | input | 3 | RAM window size code |
| ws_load | input | 1 | Load strobe for the wait count |
| ws_val | input | 3 | New wait count |
| ready | input | 1 | Off-chip memory ready |
| rom_rdata | input | 8 | On-chip ROM read data |
| ram_rdata | input | 8 | On-chip RAM read data |
| ext_rdata | input | 8 | Off-chip read data |
| rdata | output | 8 | Read data to the CPU |
| stall | output | 1 | Holds the CPU |
| int_addr | output | 16 | On-chip address bus |
| int_wdata | output | 8 | On-chip RAM write data |
| rom_rd | output | 1 | ROM read strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ext_addr | output | 24 | Off-chip address bus |
| ext_wdata | output | 8 | Off-chip write data |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_wr | output | 1 | Off-chip write strobe |

## Verification
The bench builds the block with its default parameters. These give a 24-bit address, 8-bit data and a 3-bit wait register that resets to 7. Random size codes cover every window edge, including both empty windows and the 64 kB ROM that hides the whole RAM window. The 3-bit wait count covers counts from zero to the reset value of 7. Ready-low runs are tested both shorter and longer than the count, which reaches both branches of max(W, M).

// File: rtl/pmem_wait_ctrl.sv
module pmem_wait_ctrl #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int IAW = 16,
  parameter int SZW = 3,
  parameter int WSW = 3,
  parameter logic [WSW-1:0] WS_RESET = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           rd,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  input  logic [SZW-1:0] rom_size,
  input  logic [SZW-1:0] ram_size,
  input  logic           ws_load,
  input  logic [WSW-1:0] ws_val,
  input  logic           ready,
  input  logic [DW-1:0]  rom_rdata,
  input  logic [DW-1:0]  ram_rdata,
  input  logic [DW-1:0]  ext_rdata,
  output logic [DW-1:0]  rdata,
  output logic           stall,
  output logic [IAW-1:0] int_addr,
  output logic [DW-1:0]  int_wdata,
  output logic           rom_rd,
  output logic           ram_rd,
  output logic           ram_wr,
  output logic [AW-1:0]  ext_addr,
  output logic [DW-1:0]  ext_wdata,
  output logic           ext_rd,
  output logic           ext_wr
);
  localparam int WINW = IAW + 1;
  localparam int SHW = 6;
  localparam logic [WINW-1:0] TOP = WINW'(1) << IAW;

  function automatic logic [WINW-1:0] win_bytes(input logic [SZW-1:0] code);
    if (code == '0) return '0;
    return WINW'(1) << (SHW'(code) + SHW'(IAW - (1 << SZW) + 1));
  endfunction

  logic [WINW-1:0] rom_b, ram_b;
  logic hit_rom, hit_ram, hit_ext, req, ext_req, ext_done;
  logic [WSW-1:0] ws_q, cnt_q, cnt_now;
  logic busy_q;

  assign rom_b   = win_bytes(rom_size);
  assign ram_b   = win_bytes(ram_size);
  assign hit_rom = addr < AW'(rom_b);
  assign hit_ram = !hit_rom && (addr[AW-1:IAW] == '0) &&
                   ({1'b0, addr[IAW-1:0]} >= (TOP - ram_b));
  assign hit_ext = !hit_rom && !hit_ram;
  assign req     = rd | wr;

  assign rom_rd = rd & hit_rom;
  assign ram_rd = rd & hit_ram;
  assign ram_wr = wr & hit_ram;
  assign ext_rd = rd & hit_ext;
  assign ext_wr = wr & hit_ext;

  assign int_addr  = addr[IAW-1:0];
  assign int_wdata = wdata;
  assign ext_addr  = addr;
  assign ext_wdata = wdata;
  assign rdata = hit_rom ? rom_rdata : (hit_ram ? ram_rdata : ext_rdata);

  assign ext_req  = req & hit_ext;
  assign cnt_now  = busy_q ? cnt_q : ws_q;
  assign ext_done = (cnt_now == '0) && ready;
  assign stall    = ext_req && !ext_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q   <= WS_RESET;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (ws_load) ws_q <= ws_val;
      if (ext_req && !ext_done) begin
        busy_q <= 1'b1;
        cnt_q  <= (cnt_now == '0) ? '0 : cnt_now - 1'b1;
      end else begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/pmem_wait_ctrl_chk.sv
module pmem_wait_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] addr,
  input logic        wr,
  input logic        ready,
  input logic        stall,
  input logic        rom_rd,
  input logic        ram_rd,
  input logic        ram_wr,
  input logic        ext_rd,
  input logic        ext_wr
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd, ram_rd, ram_wr, ext_rd, ext_wr}));
  a_r4_onchip_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd || ram_rd || ram_wr) |-> !stall);
  a_r5_stall_only_offchip: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ext_rd || ext_wr));
  a_r6_not_ready_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && !ready) |-> stall);
  a_r1_rom_low_64k: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (addr[23:16] == 8'h00));
  a_r8_ram_wr_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> wr);
endmodule

bind pmem_wait_ctrl pmem_wait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .ready(ready), .stall(stall),
  .rom_rd(rom_rd), .ram_rd(ram_rd), .ram_wr(ram_wr), .ext_rd(ext_rd), .ext_wr(ext_wr)
);

// File: tb/tb_pmem_wait_ctrl.sv
module tb_pmem_wait_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [23:0] addr = 0;
  logic rd = 0, wr = 0, ws_load = 0, ready = 1;
  logic [7:0] wdata = 0, rom_rdata = 8'h11, ram_rdata = 8'h22, ext_rdata = 8'h33;
  logic [2:0] rom_size = 0, ram_size = 0, ws_val = 0;
  logic [7:0] rdata, int_wdata, ext_wdata;
  logic stall, rom_rd, ram_rd, ram_wr, ext_rd, ext_wr;
  logic [15:0] int_addr;
  logic [23:0] ext_addr;
  int total = 0, bad = 0;
  bit done = 0;

  pmem_wait_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int win(input logic [2:0] c);
    return (c == 0) ? 0 : (1 << (c + 9));
  endfunction

  // 0 rom, 1 ram, 2 ext
  function automatic int region(input logic [23:0] a, input logic [2:0] rs, input logic [2:0] ms);
    if (int'(a) < win(rs)) return 0;
    if (int'(a) < 65536 && int'(a) >= 65536 - win(ms)) return 1;
    return 2;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic decode_check(input logic [23:0] a, input bit w);
    int r;
    @(negedge clk);
    addr = a; rd = !w; wr = w;
    wdata = 8'($urandom); rom_rdata = 8'($urandom); ram_rdata = 8'($urandom); ext_rdata = 8'($urandom);
    #1;
    r = region(a, rom_size, ram_size);
    check("R1 rom_rd", rom_rd, !w && r == 0);
    check("R2 ram strobes", {ram_rd, ram_wr}, {!w && r == 1, w && r == 1});
    check("R3 ext strobes", {ext_rd, ext_wr}, {!w && r == 2, w && r == 2});
    check("R4 no on-chip stall", stall, (r == 2) ? stall : 1'b0);
    check("R9 int_addr", int_addr, a[15:0]);
    check("R3 ext_addr", ext_addr, a);
    if (!w) check("R9 rdata", rdata, (r == 0) ? rom_rdata : (r == 1) ? ram_rdata : ext_rdata);
    else begin
      check("R8 wdata", {int_wdata, ext_wdata}, {wdata, wdata});
      if (r == 0) check("R8 rom write ignored", {rom_rd, ram_wr, ext_wr, stall}, 0);
    end
    #1 rd = 0; wr = 0;
  endtask

  task automatic set_ws(input logic [2:0] v);
    @(negedge clk); ws_load = 1; ws_val = v;
    @(negedge clk); ws_load = 0;
  endtask

  task automatic ext_access(input string req, input bit w, input int m, input int exp_n);
    int n = 0;
    @(negedge clk);
    addr = 24'h123456; rd = !w; wr = w; ready = (m == 0);
    #1;
    while (stall && n < 50) begin
      @(posedge clk); #1; n++;
      ready = (n >= m);
      #1;
    end
    check(req, n, exp_n);
    @(negedge clk); rd = 0; wr = 0; ready = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R4 reset idle stall", stall, 0);
    rom_size = 1; ram_size = 4;
    ext_access("R7 reset wait count 7", 0, 0, 7);
    decode_check(24'h0003FF, 0);
    decode_check(24'h000400, 0);
    decode_check(24'h00E000, 1);
    decode_check(24'h00DFFF, 1);
    decode_check(24'h00FFFF, 0);
    decode_check(24'h010000, 0);
    decode_check(24'h000010, 1);
    rom_size = 7; ram_size = 7;
    decode_check(24'h00FFFF, 0);
    decode_check(24'h00FFFF, 1);
    rom_size = 0; ram_size = 0;
    decode_check(24'h000000, 0);
    decode_check(24'h00FFFF, 1);
    decode_check(24'hFFFFFF, 0);
    for (int i = 0; i < 300; i++) begin
      logic [23:0] a;
      rom_size = 3'($urandom); ram_size = 3'($urandom);
      case ($urandom % 3)
        0: a = 24'($urandom % 65536);
        1: a = 24'(65536 - 1 - ($urandom % 4096));
        default: a = 24'($urandom);
      endcase
      decode_check(a, 1'($urandom));
    end
    rom_size = 1; ram_size = 1;
    set_ws(0);
    ext_access("R5 zero waits", 0, 0, 0);
    ext_access("R6 ready low with zero waits", 0, 3, 3);
    set_ws(3);
    ext_access("R5 three waits", 0, 0, 3);
    ext_access("R8 off-chip write waits", 1, 0, 3);
    ext_access("R6 short ready low", 0, 2, 3);
    ext_access("R6 long ready low", 0, 6, 6);
    for (int i = 0; i < 20; i++) begin
      int w = $urandom % 8;
      int m = $urandom % 10;
      set_ws(3'(w));
      ext_access("R6 random ready", 1'($urandom), m, (w > m) ? w : m);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule